// File: doc/BRIEF.md
# MDIO Management Target

This block is the serial management target that sits inside an Ethernet PHY. It runs entirely on the management clock (MDC). It watches the shared MDIO line, which is split here into a sampled input, a driven output and an output enable. It decodes management frames and gives 16-bit read and write access to a small bank of control and status registers. The bank holds a standard group at addresses 0 to 7 and two extended registers at 16 and 17.

The PHY address is captured from five strap inputs on the first MDC edge after reset and then held. The target answers frames that carry that address and also frames that carry address 00000. It keeps MDIO released unless it is returning data for a read that selects it, so many targets can share one line. A change on any monitored status input latches an interrupt bit and raises the interrupt output. Reading the interrupt status register clears the latched bits.

Top module: `mdio_target`

## Requirements
- R1: The 5-bit PHY address is taken from `strap_addr_i` on the first MDC rising edge after reset is released. It is held until the next reset, and later strap changes have no effect.
- R2: A frame is accepted when its PHY address field equals the captured address or equals 00000. For any other address the target never drives MDIO and ignores writes.
- R3: `mdio_oe_o` is low whenever no read data phase for a selected read frame is in progress.
- R4: Decoding starts only after at least 32 consecutive ones have been sampled on MDIO. A frame preceded by 31 ones is ignored.
- R5: After the preamble the frame must carry start bits 0,1 and then opcode 1,0 (read) or 0,1 (write), all MSB first. Any other start or opcode value abandons the frame, and a fresh 32-one preamble is needed before the next frame is decoded.
- R6: Frame layout after the opcode: 5-bit PHY address, 5-bit register address, 2 turnaround bits, 16 data bits, all MSB first and sampled on the MDC rising edge. On a selected read, MDIO stays released during the first turnaround bit and is driven 0 during the second. The 16 data bits are then driven MSB first, one per MDC period, each changing after a rising edge, and MDIO is released after the last bit.
- R7: On a selected write, the 16 data bits are stored in the addressed writable register when the last data bit is sampled.
- R8: Register map: 0 control (read/write, reset value `CTRL_RST`, default 16'h1000); 1 live status, with bits [N_STAT-1:0] showing the synchronized status inputs and zeros above; 2 and 3 fixed identifier words (`ID_HI` default 16'h00A5, `ID_LO` default 16'h3C01); 4 to 7 read/write, reset 0; 16 interrupt status (read only); 17 extended control (read/write, reset 0).
- R9: Reads of any other register address return 0, and writes to them or to read-only registers are ignored.
- R10: A change in either direction on status input bit i sets bit i of register 16 and drives `irq_o` high within 4 MDC edges. A selected read of register 16 returns the latched bits and clears them, which drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc_i | input | 1 | Management clock; MDIO is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled value of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe_o | output | 1 | MDIO output enable |
| strap_addr_i | input | 5 | PHY address straps |
| status_i | input | N_STAT | Monitored status inputs (default 4) |
| irq_o | output | 1 | Interrupt, high while any status-change bit is latched |

## Verification
Reads of one identifier register are swept across all 32 PHY addresses after the straps have been moved away from their captured value. This separates the captured address and the broadcast address from the other 30 addresses, and from the live strap value. Writes and reads of distinct patterns cover all 32 register addresses, which separates writable, read-only, fixed and unimplemented locations. Frames with a 31-one preamble, a bad start field and a bad opcode, each followed by a frame with no fresh preamble, show that preamble counting and the abandon path both work. Status toggles on single and multiple bits check the latch, the bit position and the clear-on-read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W = 16;
  localparam int ADR_W = 5;

  localparam logic [ADR_W-1:0] ADDR_CTRL  = 5'd0;
  localparam logic [ADR_W-1:0] ADDR_STAT  = 5'd1;
  localparam logic [ADR_W-1:0] ADDR_ID_HI = 5'd2;
  localparam logic [ADR_W-1:0] ADDR_ID_LO = 5'd3;
  localparam logic [ADR_W-1:0] ADDR_IRQ   = 5'd16;
  localparam logic [ADR_W-1:0] ADDR_XCTL  = 5'd17;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_START,
    ST_OP,
    ST_HDR,
    ST_TA,
    ST_DATA
  } mdio_st_e;
endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mdio_i,
  input  logic [ADR_W-1:0] own_addr_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic [ADR_W-1:0] reg_addr_o,
  output logic             rd_take_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  localparam int CNT_W = $clog2(PRE_LEN + 1);
  localparam int HDR_W = 2 * ADR_W;
  localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(PRE_LEN);
  localparam logic [3:0] HDR_LAST = 4'(HDR_W - 1);
  localparam logic [3:0] DAT_LAST = 4'(REG_W - 1);

  mdio_st_e         st_q;
  logic [CNT_W-1:0] ones_q;
  logic [3:0]       bit_q;
  logic             op_hi_q;
  logic             is_rd_q;
  logic             sel_q;
  logic [HDR_W-2:0] hdr_q;
  logic [ADR_W-1:0] reg_addr_q;
  logic [REG_W-1:0] sh_q;
  logic             oe_q;
  logic             out_q;

  logic             drive;
  logic [HDR_W-1:0] hdr_full;
  logic [1:0]       op_full;
  logic             op_ok;

  assign drive    = is_rd_q & sel_q;
  assign hdr_full = {hdr_q, mdio_i};
  assign op_full  = {op_hi_q, mdio_i};
  assign op_ok    = (op_full == OP_RD) || (op_full == OP_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_PRE;
      ones_q     <= '0;
      bit_q      <= '0;
      op_hi_q    <= 1'b0;
      is_rd_q    <= 1'b0;
      sel_q      <= 1'b0;
      hdr_q      <= '0;
      reg_addr_q <= '0;
      sh_q       <= '0;
      oe_q       <= 1'b0;
      out_q      <= 1'b1;
    end else begin
      unique case (st_q)
        ST_PRE: begin
          if (mdio_i) begin
            if (ones_q != PRE_MAX) ones_q <= ones_q + 1'b1;
          end else if (ones_q == PRE_MAX) begin
            st_q   <= ST_START;  // this zero is the first start bit
            ones_q <= '0;
          end else begin
            ones_q <= '0;
          end
        end
        ST_START: begin
          bit_q <= '0;
          st_q  <= mdio_i ? ST_OP : ST_PRE;
        end
        ST_OP: begin
          if (bit_q == 4'd0) begin
            op_hi_q <= mdio_i;
            bit_q   <= 4'd1;
          end else if (op_ok) begin
            is_rd_q <= (op_full == OP_RD);
            bit_q   <= '0;
            st_q    <= ST_HDR;
          end else begin
            st_q <= ST_PRE;
          end
        end
        ST_HDR: begin
          hdr_q <= hdr_full[HDR_W-2:0];
          if (bit_q == HDR_LAST) begin
            sel_q      <= (hdr_full[HDR_W-1:ADR_W] == own_addr_i) ||
                          (hdr_full[HDR_W-1:ADR_W] == '0);
            reg_addr_q <= hdr_full[ADR_W-1:0];
            bit_q      <= '0;
            st_q       <= ST_TA;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_TA: begin
          if (bit_q == 4'd0) begin
            bit_q <= 4'd1;
            if (drive) begin
              oe_q  <= 1'b1;
              out_q <= 1'b0;
              sh_q  <= rd_data_i;
            end
          end else begin
            bit_q <= '0;
            st_q  <= ST_DATA;
            if (drive) begin
              out_q <= sh_q[REG_W-1];
              sh_q  <= {sh_q[REG_W-2:0], 1'b0};
            end
          end
        end
        ST_DATA: begin
          if (bit_q == DAT_LAST) begin
            oe_q  <= 1'b0;
            out_q <= 1'b1;
            st_q  <= ST_PRE;
          end else begin
            bit_q <= bit_q + 1'b1;
            if (drive) begin
              out_q <= sh_q[REG_W-1];
              sh_q  <= {sh_q[REG_W-2:0], 1'b0};
            end else begin
              sh_q <= {sh_q[REG_W-2:0], mdio_i};
            end
          end
        end
        default: st_q <= ST_PRE;
      endcase
    end
  end

  assign reg_addr_o = reg_addr_q;
  assign rd_take_o  = (st_q == ST_TA) && (bit_q == 4'd0) && drive;
  assign wr_en_o    = (st_q == ST_DATA) && (bit_q == DAT_LAST) && !is_rd_q && sel_q;
  assign wr_data_o  = {sh_q[REG_W-2:0], mdio_i};
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;

  // R3
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE || st_q == ST_START || st_q == ST_OP || st_q == ST_HDR) |-> !mdio_oe_o);

  // R2
  oe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (sel_q && is_rd_q));

  // R6
  ta_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> (!mdio_o && st_q == ST_TA));

  // R4
  short_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE && !mdio_i && ones_q != PRE_MAX) |=> (st_q == ST_PRE));

  // R5
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OP && bit_q == 4'd1 && !op_ok) |=> (st_q == ST_PRE && ones_q == '0));
endmodule

// File: rtl/mdio_irq_ctrl.sv
module mdio_irq_ctrl #(
  parameter int N_STAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STAT-1:0] status_i,
  input  logic              clr_i,
  output logic [N_STAT-1:0] stat_o,
  output logic [N_STAT-1:0] lat_o,
  output logic              irq_o
);
  logic [N_STAT-1:0] sync1_q, sync2_q, prev_q, lat_q;
  logic [N_STAT-1:0] chg;

  assign chg = sync2_q ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      lat_q   <= '0;
    end else begin
      sync1_q <= status_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      lat_q   <= (clr_i ? '0 : lat_q) | chg;  // a new change wins over the clear
    end
  end

  assign stat_o = sync2_q;
  assign lat_o  = lat_q;
  assign irq_o  = |lat_q;

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chg) |=> irq_o);

  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|chg)) |=> !irq_o);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter int              N_STAT   = 4,
  parameter logic [REG_W-1:0] CTRL_RST = 16'h1000,
  parameter logic [REG_W-1:0] ID_HI    = 16'h00A5,
  parameter logic [REG_W-1:0] ID_LO    = 16'h3C01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [N_STAT-1:0] stat_i,
  input  logic [N_STAT-1:0] irq_lat_i,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int N_RW  = 6;
  localparam int PAD_W = REG_W - N_STAT;

  function automatic logic [ADR_W-1:0] slot_addr(input int idx);
    if (idx == 0) return ADDR_CTRL;
    if (idx == N_RW - 1) return ADDR_XCTL;
    return ADR_W'(idx + 3);  // slots 1..4 map to 4..7
  endfunction

  function automatic logic is_rw(input logic [ADR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N_RW; k++) if (a == slot_addr(k)) hit = 1'b1;
    return hit;
  endfunction

  logic [REG_W-1:0] rw_q [N_RW];

  for (genvar g = 0; g < N_RW; g++) begin : g_rw
    localparam logic [REG_W-1:0] RST_VAL = (g == 0) ? CTRL_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rw_q[g] <= RST_VAL;
      else if (wr_en_i && addr_i == slot_addr(g)) rw_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      ADDR_STAT:  rd_data_o = {{PAD_W{1'b0}}, stat_i};
      ADDR_ID_HI: rd_data_o = ID_HI;
      ADDR_ID_LO: rd_data_o = ID_LO;
      ADDR_IRQ:   rd_data_o = {{PAD_W{1'b0}}, irq_lat_i};
      default: begin
        for (int k = 0; k < N_RW; k++)
          if (addr_i == slot_addr(k)) rd_data_o = rw_q[k];
      end
    endcase
  end

  // R7
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_rw(addr_i)) |=> (rd_data_o == $past(wr_data_i)));
endmodule

// File: rtl/mdio_target.sv
module mdio_target
  import mdio_pkg::*;
#(
  parameter int               N_STAT   = 4,
  parameter int               PRE_LEN  = 32,
  parameter logic [REG_W-1:0] CTRL_RST = 16'h1000,
  parameter logic [REG_W-1:0] ID_HI    = 16'h00A5,
  parameter logic [REG_W-1:0] ID_LO    = 16'h3C01
) (
  input  logic              mdc_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic [4:0]        strap_addr_i,
  input  logic [N_STAT-1:0] status_i,
  output logic              irq_o
);
  logic [ADR_W-1:0]  strap_q;
  logic              strap_vld_q;
  logic [ADR_W-1:0]  reg_addr;
  logic              rd_take, wr_en;
  logic [REG_W-1:0]  wr_data, rd_data;
  logic [N_STAT-1:0] stat_sync, irq_lat;
  logic              irq_clr;

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q     <= '0;
      strap_vld_q <= 1'b0;
    end else if (!strap_vld_q) begin
      strap_q     <= strap_addr_i;
      strap_vld_q <= 1'b1;
    end
  end

  assign irq_clr = rd_take && (reg_addr == ADDR_IRQ);

  mdio_frame_ctrl #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .own_addr_i (strap_q),
    .rd_data_i  (rd_data),
    .reg_addr_o (reg_addr),
    .rd_take_o  (rd_take),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  mdio_irq_ctrl #(.N_STAT(N_STAT)) u_irq (
    .clk_i    (mdc_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .clr_i    (irq_clr),
    .stat_o   (stat_sync),
    .lat_o    (irq_lat),
    .irq_o    (irq_o)
  );

  mdio_reg_bank #(
    .N_STAT   (N_STAT),
    .CTRL_RST (CTRL_RST),
    .ID_HI    (ID_HI),
    .ID_LO    (ID_LO)
  ) u_regs (
    .clk_i     (mdc_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .stat_i    (stat_sync),
    .irq_lat_i (irq_lat),
    .rd_data_o (rd_data)
  );

  // R1
  strap_hold_chk: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    strap_vld_q |=> $stable(strap_q));
endmodule

// File: tb/mdio_target_tb.sv
module mdio_target_tb;
  localparam logic [15:0] CTRL_RST = 16'h1000;
  localparam logic [15:0] ID_HI    = 16'h00A5;
  localparam logic [15:0] ID_LO    = 16'h3C01;
  localparam logic [4:0]  MY_ADDR  = 5'd9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_drv = 1'b1;
  logic       dut_out, dut_oe, irq;
  logic       line;
  logic [4:0] strap = MY_ADDR;
  logic [3:0] status = 4'h0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  assign line = dut_oe ? dut_out : host_drv;

  mdio_target u_dut (
    .mdc_i        (clk),
    .rst_ni       (rst_n),
    .mdio_i       (line),
    .mdio_o       (dut_out),
    .mdio_oe_o    (dut_oe),
    .strap_addr_i (strap),
    .status_i     (status),
    .irq_o        (irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic b);
    @(negedge clk);
    host_drv = b;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) put(1'b1);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    put(1'b0); put(1'b1);
    put(op[1]); put(op[0]);
    for (int i = 4; i >= 0; i--) put(phy[i]);
    for (int i = 4; i >= 0; i--) put(ra[i]);
  endtask

  // Read frame; protocol outcome is checked here, data returned
  task automatic mdio_read(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                           input logic resp, input string tag, output logic [15:0] d);
    logic ok;
    ok = 1'b1;
    d  = '0;
    send_ones(pre);
    send_hdr(2'b10, phy, ra);
    @(negedge clk); host_drv = 1'b1;
    if (dut_oe) ok = 1'b0;
    @(negedge clk);
    if (resp ? !(dut_oe && !line) : dut_oe) ok = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      d = {d[14:0], line};
      if (dut_oe !== resp) ok = 1'b0;
    end
    @(negedge clk);
    if (dut_oe) ok = 1'b0;
    check({tag, " drive"}, {15'd0, ok}, 16'd1);
  endtask

  task automatic mdio_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_ones(32);
    send_hdr(2'b01, phy, ra);
    put(1'b1); put(1'b0);
    for (int i = 15; i >= 0; i--) put(d[i]);
    put(1'b1);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'h9000 + 16'(a) * 16'h0101;
  endfunction

  function automatic logic [15:0] exp_reg(input int a, input logic [3:0] st);
    if (a == 0 || (a >= 4 && a <= 7) || a == 17) return pat(a);
    if (a == 1) return {12'd0, st};
    if (a == 2) return ID_HI;
    if (a == 3) return ID_LO;
    return 16'h0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = 5'd3;  // R1: must not move the captured address
    @(negedge clk);

    // R3 reset state
    check("R3 oe after reset", {15'd0, dut_oe}, 16'd0);
    check("R10 irq after reset", {15'd0, irq}, 16'd0);

    mdio_read(32, MY_ADDR, 5'd0, 1'b1, "R6", d);
    check("R8 ctrl reset", d, CTRL_RST);

    // R1 R2: PHY address sweep
    for (int p = 0; p < 32; p++) begin
      logic resp;
      resp = (p == 0) || (p == int'(MY_ADDR));
      mdio_read(32, 5'(p), 5'd2, resp, resp ? "R2 R6 sel" : "R1 R2 unsel", d);
      if (resp) check("R2 id via addr", d, ID_HI);
    end

    // R7 R8 R9: write every register address, then read all back
    for (int a = 0; a < 32; a++) mdio_write(MY_ADDR, 5'(a), pat(a));
    for (int a = 0; a < 32; a++) begin
      mdio_read(32, MY_ADDR, 5'(a), 1'b1, "R6", d);
      check((a == 0 || (a >= 4 && a <= 7) || a == 17) ? "R7 rw readback" :
            (a <= 3) ? "R8 fixed reg" : "R9 unimpl reg", d, exp_reg(a, 4'h0));
    end

    // R2: write to foreign address ignored, broadcast write accepted
    mdio_write(5'd7, 5'd4, 16'hDEAD);
    mdio_read(32, MY_ADDR, 5'd4, 1'b1, "R6", d);
    check("R2 foreign write ignored", d, pat(4));
    mdio_write(5'd0, 5'd5, 16'hBEEF);
    mdio_read(32, MY_ADDR, 5'd5, 1'b1, "R6", d);
    check("R2 broadcast write", d, 16'hBEEF);

    // R4: 31 ones is not enough
    host_drv = 1'b0; put(1'b0);
    mdio_read(31, MY_ADDR, 5'd2, 1'b0, "R4 short preamble", d);

    // R5: bad start, then frame without fresh preamble
    send_ones(32); put(1'b0); put(1'b0);
    mdio_read(0, MY_ADDR, 5'd2, 1'b0, "R5 bad start", d);
    // R5: bad opcode 11, then frame without fresh preamble
    send_ones(32); put(1'b0); put(1'b1); put(1'b1); put(1'b1);
    mdio_read(0, MY_ADDR, 5'd2, 1'b0, "R5 bad opcode", d);
    // R5: bad opcode 00
    send_ones(32); put(1'b0); put(1'b1); put(1'b0); put(1'b0);
    mdio_read(0, MY_ADDR, 5'd2, 1'b0, "R5 bad opcode 00", d);
    mdio_read(32, MY_ADDR, 5'd3, 1'b1, "R5 recovery", d);
    check("R5 recovery data", d, ID_LO);

    // R10 R8: status change interrupt
    status = 4'b0101;
    repeat (5) @(negedge clk);
    check("R10 irq set", {15'd0, irq}, 16'd1);
    mdio_read(32, MY_ADDR, 5'd1, 1'b1, "R6", d);
    check("R8 live status", d, 16'h0005);
    check("R10 irq held", {15'd0, irq}, 16'd1);
    mdio_read(32, MY_ADDR, 5'd16, 1'b1, "R6", d);
    check("R10 irq bits", d, 16'h0005);
    check("R10 irq cleared", {15'd0, irq}, 16'd0);
    mdio_read(32, MY_ADDR, 5'd16, 1'b1, "R6", d);
    check("R10 irq reg cleared", d, 16'h0000);
    status = 4'b1101;
    repeat (5) @(negedge clk);
    check("R10 irq set bit3", {15'd0, irq}, 16'd1);
    mdio_read(32, 5'd0, 5'd16, 1'b1, "R6", d);
    check("R10 irq bit3 only", d, 16'h0008);
    status = 4'b0100;
    repeat (5) @(negedge clk);
    mdio_read(32, MY_ADDR, 5'd16, 1'b1, "R6", d);
    check("R10 falling edges", d, 16'h0009);
    mdio_read(32, MY_ADDR, 5'd1, 1'b1, "R6", d);
    check("R8 status after fall", d, 16'h0004);
    check("R3 oe idle end", {15'd0, dut_oe}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule